// File: doc/BRIEF.md
# Display Update Stage Sequencer

This block orders the stages of a panel refresh. An 8-bit option register selects which stages take part. Bit 7 is clock/oscillator on. Bit 6 is charge pump on. Bit 5 is temperature load. Bit 4 is waveform table load. Bit 3 is initial display. Bit 2 is pattern display. Bit 1 is charge pump off. Bit 0 is clock/oscillator off. The stage work itself is done by external workers. The sequencer only starts them, waits for them and reports that it is busy.

A run begins when the activation input is sampled high while the block is idle. At that edge the option value is captured into a pending mask. The sequencer then raises a one-hot request for the highest pending stage. It holds that request until the matching done line returns. It then clears that stage and moves straight to the next highest pending stage. No cycles are spent on stages that are not selected.

While a run is in progress, new activations and option writes are both refused. After the last stage, busy stays high for one more cycle. A one-cycle completion pulse follows in the first idle cycle.

The controller has three states. `ST_IDLE` waits for activation. `ST_WAIT` drives the request for the current stage. `ST_FINISH` is the closing busy cycle. The transitions are:
- `ST_IDLE` to `ST_WAIT` on an activation with a non-zero mask.
- `ST_IDLE` to `ST_FINISH` on an activation with an empty mask.
- `ST_WAIT` to `ST_WAIT` when the current stage is done and other stages are still pending.
- `ST_WAIT` to `ST_FINISH` when the last pending stage is done.
- `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `upd_seq_top`

## Requirements
- R1: After reset, busy, seq_done and stage_req are all 0, and the option register holds 0x00. An activation right after reset therefore gives a single busy cycle with no request.
- R2: Requests are issued in strictly falling bit order. stage_req bit i serves option bit i (bit 7 clock on, 6 pump on, 5 temperature, 4 table load, 3 initial display, 2 pattern, 1 pump off, 0 clock off). Only stages whose option bit was captured as 1 are requested.
- R3: A stage's request stays high until stage_done carries a 1 on that same bit. A done on any other bit has no effect.
- R4: In the cycle after the edge that samples the current stage's done, the request of the next captured stage is already high. Unselected stages take no cycles.
- R5: Busy is high starting in the cycle after the edge that samples activation. It stays high without a gap, and is still high in the cycle after the edge that samples the last done. It is low in the cycle after that.
- R6: With an all-zero captured mask, busy is high for exactly one cycle and no request is raised.
- R7: seq_done is high for exactly one cycle, the first cycle in which busy is low after a run.
- R8: An activation sampled while busy is high is ignored. After the run ends, no second run starts.
- R9: An option write sampled while busy is high is dropped. The register keeps its earlier value, which a later run shows.
- R10: If an option write and an activation are sampled at the same idle edge, the run uses the earlier register value. The written value is used by the next run.
- R11: stage_req has at most one bit set, and is all-zero whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option value to write |
| activate | input | 1 | Start request for the update sequence |
| stage_done | input | 8 | Per-stage completion from the external workers |
| stage_req | output | 8 | One-hot per-stage request |
| busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse when a sequence has ended |

## Verification
Some properties are checked by the assertions on every cycle:
- the request vector is one-hot or zero, and is zero whenever busy is low;
- a held request never changes without its own done;
- a change of request always moves to a lower bit;
- busy rises only after an activation;
- the completion pulse lasts one cycle and follows a busy cycle.

Other behaviours only the bench scenarios can show, because they depend on the register contents seen at the ports over whole runs:
- the exact cycle counts of busy;
- the absence of gaps for unselected stages;
- the refusal of activations and option writes during a run;
- which option value a run uses when a write and an activation arrive together.

// File: rtl/upd_seq_pkg.sv
package upd_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

    // Stage positions in the option word; priority runs from high to low
    localparam int STG_CLK_ON   = 7;
    localparam int STG_PUMP_ON  = 6;
    localparam int STG_TEMP     = 5;
    localparam int STG_TABLE    = 4;
    localparam int STG_INIT     = 3;
    localparam int STG_PATTERN  = 2;
    localparam int STG_PUMP_OFF = 1;
    localparam int STG_CLK_OFF  = 0;

endpackage

// File: rtl/upd_seq_optreg.sv
module upd_seq_optreg #(
    parameter int          WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             lock,
    output logic [WIDTH-1:0] opt_q
);

    // Writes are refused while a sequence holds the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q <= RST_VAL;
        end else if (wr_en && !lock) begin
            opt_q <= wr_data;
        end
    end

endmodule

// File: rtl/upd_seq_prienc.sv
module upd_seq_prienc #(
    parameter int WIDTH = 8,
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req,
    output logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] onehot,
    output logic             any
);

    // Highest set bit wins: later loop iterations override earlier ones
    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        onehot = '0;
        if (|req) begin
            onehot[idx] = 1'b1;
        end
    end

    assign any = |req;

endmodule

// File: rtl/upd_seq_fsm.sv
module upd_seq_fsm
    import upd_seq_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              activate,
    input  logic [STAGES-1:0] opt_q,
    input  logic [STAGES-1:0] stage_done,
    output logic [STAGES-1:0] stage_req,
    output logic              busy,
    output logic              seq_done
);

    localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    seq_state_e        state_q, state_d;
    logic [STAGES-1:0] pending_q, pending_d;
    logic [IDX_W-1:0]  cur_idx;
    logic [STAGES-1:0] cur_onehot;
    logic              cur_any;
    logic              cur_done;

    upd_seq_prienc #(
        .WIDTH (STAGES),
        .IDX_W (IDX_W)
    ) u_pick (
        .req    (pending_q),
        .idx    (cur_idx),
        .onehot (cur_onehot),
        .any    (cur_any)
    );

    assign cur_done = |(stage_done & cur_onehot);

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        pending_d = pending_q;
        unique case (state_q)
            ST_IDLE: begin
                if (activate) begin
                    pending_d = opt_q;
                    state_d   = (|opt_q) ? ST_WAIT : ST_FINISH;
                end
            end
            ST_WAIT: begin
                if (!cur_any) begin
                    state_d = ST_FINISH;
                end else if (cur_done) begin
                    pending_d = pending_q & ~cur_onehot;
                    state_d   = (|pending_d) ? ST_WAIT : ST_FINISH;
                end
            end
            ST_FINISH: begin
                pending_d = '0;
                state_d   = ST_IDLE;
            end
            default: begin
                pending_d = '0;
                state_d   = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            seq_done  <= 1'b0;
        end else begin
            state_q   <= state_d;
            pending_q <= pending_d;
            seq_done  <= (state_q == ST_FINISH);
        end
    end

    // Outputs
    always_comb begin
        stage_req = '0;
        busy      = (state_q != ST_IDLE);
        if (state_q == ST_WAIT) begin
            stage_req = cur_onehot;
        end
    end

endmodule

// File: rtl/upd_seq_top.sv
module upd_seq_top #(
    parameter int                STAGES  = 8,
    parameter logic [STAGES-1:0] OPT_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_wr,
    input  logic [STAGES-1:0] opt_wdata,
    input  logic              activate,
    input  logic [STAGES-1:0] stage_done,
    output logic [STAGES-1:0] stage_req,
    output logic              busy,
    output logic              seq_done
);

    logic [STAGES-1:0] opt_q;

    upd_seq_optreg #(
        .WIDTH   (STAGES),
        .RST_VAL (OPT_RST)
    ) u_opt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (opt_wr),
        .wr_data (opt_wdata),
        .lock    (busy),
        .opt_q   (opt_q)
    );

    upd_seq_fsm #(
        .STAGES (STAGES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .activate   (activate),
        .opt_q      (opt_q),
        .stage_done (stage_done),
        .stage_req  (stage_req),
        .busy       (busy),
        .seq_done   (seq_done)
    );

endmodule

// File: rtl/upd_seq_chk.sv
module upd_seq_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              opt_wr,
    input logic [STAGES-1:0] opt_wdata,
    input logic              activate,
    input logic [STAGES-1:0] stage_done,
    input logic [STAGES-1:0] stage_req,
    input logic              busy,
    input logic              seq_done
);

    // R11
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_req));

    // R11
    req_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stage_req == '0));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_req != '0) && ((stage_req & stage_done) == '0))
        |=> (stage_req == $past(stage_req)));

    // R2
    req_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_req != '0) && ($past(stage_req) != '0)
         && (stage_req != $past(stage_req)))
        |-> (stage_req < $past(stage_req)));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(activate));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy && $past(busy)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

endmodule

bind upd_seq_top upd_seq_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/upd_seq_top_test.sv
module upd_seq_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_wr = 1'b0;
    logic [7:0] opt_wdata = '0;
    logic       activate = 1'b0;
    logic [7:0] stage_done = '0;
    logic [7:0] stage_req;
    logic       busy;
    logic       seq_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // 125 MHz
    always #4 clk = ~clk;

    upd_seq_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opt_wr     (opt_wr),
        .opt_wdata  (opt_wdata),
        .activate   (activate),
        .stage_done (stage_done),
        .stage_req  (stage_req),
        .busy       (busy),
        .seq_done   (seq_done)
    );

    // {mask, wait cycles before done}
    localparam logic [11:0] VEC [8] = '{
        {8'hFF, 4'd0}, {8'h81, 4'd2}, {8'h3C, 4'd1}, {8'h01, 4'd3},
        {8'h80, 4'd0}, {8'hA5, 4'd1}, {8'h00, 4'd0}, {8'h42, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // wmode: 0 no write, 1 write before activation, 2 write on the activation cycle
    // poke: bit0 activation during first wait, bit1 write 0xFF during first wait
    task automatic run_seq(input logic [7:0] exp_mask, input logic [7:0] wdata,
                           input int wmode, input int poke, input int lat);
        bit first = 1'b1;
        if (wmode == 1) begin
            @(negedge clk); opt_wr = 1'b1; opt_wdata = wdata;
            @(negedge clk); opt_wr = 1'b0;
        end
        @(negedge clk);
        activate = 1'b1;
        if (wmode == 2) begin opt_wr = 1'b1; opt_wdata = wdata; end
        @(negedge clk);
        activate = 1'b0; opt_wr = 1'b0;
        chk(busy === 1'b1, "R5 busy after activation", int'(busy), 1);
        for (int i = 7; i >= 0; i--) begin
            if (exp_mask[i]) begin
                chk(stage_req === (8'h1 << i), "R2 R4 request order", int'(stage_req), int'(8'h1 << i));
                chk(busy === 1'b1, "R5 busy held", int'(busy), 1);
                if (first) begin
                    first = 1'b0;
                    if (poke[0]) activate = 1'b1;
                    if (poke[1]) begin opt_wr = 1'b1; opt_wdata = 8'hFF; end
                    stage_done = ~(8'h1 << i);
                    @(negedge clk);
                    activate = 1'b0; opt_wr = 1'b0; stage_done = '0;
                    chk(stage_req === (8'h1 << i), "R3 foreign done ignored", int'(stage_req), int'(8'h1 << i));
                end
                for (int w = 0; w < lat; w++) begin
                    stage_done = ~(8'h1 << i);
                    @(negedge clk);
                    chk(stage_req === (8'h1 << i), "R3 request held", int'(stage_req), int'(8'h1 << i));
                end
                stage_done = 8'h1 << i;
                @(negedge clk);
                stage_done = '0;
            end
        end
        chk(busy === 1'b1 && stage_req === 8'h00, "R5 R6 closing busy cycle",
            int'({busy, stage_req}), 32'h100);
        @(negedge clk);
        chk(busy === 1'b0, "R5 busy falls", int'(busy), 0);
        chk(seq_done === 1'b1, "R7 completion pulse", int'(seq_done), 1);
        @(negedge clk);
        chk(seq_done === 1'b0, "R7 pulse one cycle", int'(seq_done), 0);
        chk(busy === 1'b0, "R8 no restart", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && seq_done === 1'b0 && stage_req === 8'h00, "R1 reset outputs",
            int'({busy, seq_done, stage_req}), 0);
        rst_n = 1'b1;
        // R1: reset value 0x00 gives an empty run; R6
        run_seq(8'h00, 8'h00, 0, 0, 0);
        // table walk
        for (int k = 0; k < 8; k++) begin
            run_seq(VEC[k][11:4], VEC[k][11:4], 1, 0, int'(VEC[k][3:0]));
        end
        // R8: activation during run is ignored
        run_seq(8'h24, 8'h24, 1, 1, 1);
        // R9: write during run dropped; next run still uses 0x24
        run_seq(8'h24, 8'h24, 0, 2, 0);
        run_seq(8'h24, 8'h00, 0, 0, 0);
        // R10: write on the activation cycle; run uses old 0x24, next uses 0x90
        run_seq(8'h24, 8'h90, 2, 0, 0);
        run_seq(8'h90, 8'h00, 0, 0, 1);
        // R1: reset in the middle of a run returns to idle
        @(negedge clk); opt_wr = 1'b1; opt_wdata = 8'h10;
        @(negedge clk); opt_wr = 1'b0; activate = 1'b1;
        @(negedge clk); activate = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && stage_req === 8'h00, "R1 reset aborts run", int'({busy, stage_req}), 0);
        rst_n = 1'b1;
        run_seq(8'h00, 8'h00, 0, 0, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule